// File: doc/BRIEF.md
# Serial slice output pin multiplexer

This block sits between a bank of shift-register slices and a row of output pins. It holds one small configuration word per pin. Each word picks what drives the pin: a slice data stream 1, 2, 4 or 8 bits wide, a plain GPIO output bit, or a slice clock. The same word also picks where the pin's output enable comes from, either a static enable register bit or a bit taken from another slice. In a W-bit mode, pins are grouped in aligned runs of W. Every pin of a group reads its own bit of the parallel tap of the slice that shares the group's base index. A wide output-enable mode gates the group's lowest pin with one enable bit and all its higher pins with a second bit.

Software writes the configuration words through a synchronous write port with one address per pin. The pin data and pin enables are combinational. They are formed from the registered configuration and the live slice, clock and GPIO inputs. There is one slice per pin. The 8-bit data mode is allowed only from a fixed set of slices. Any other selection, and every reserved code, drives the pin low. When a wide data mode is used, the feeding slice must shift by the pin width on each slice clock. When a wide enable mode is used, the enable slice must shift 2 bits per clock.

Top module: `sgp_pin_mux`

## Requirements
- R1: A write with `cfg_we` high at a clock edge loads `cfg_wdata` into the word of pin `cfg_addr` only. The new selection shows on the pins right after that edge, and the words of all other pins keep their values.
- R2: While `rst_n` is low every word is cleared to 0. In that state pin n drives bit 0 of slice n's tap, with enable `gpio_oe[n]`.
- R3: The data field is `cfg_wdata[2:0]`. Codes 0, 1, 2 and 3 select widths W = 1, 2, 4 and 8. Pin n then drives bit (n mod W) of the tap of slice (n − n mod W). The tap of slice s is `slice_tap[s*8 +: 8]`.
- R4: The 8-bit data mode (code 3) is legal only when the group base slice is set in `WIDE8_MASK`. By default that is slice 0 only, so pins 0–7 are legal. Pins 8–15 in code 3 drive 0.
- R5: Data code 4 drives pin n from `gpio_out[n]`.
- R6: Data code 5 drives pin n from `slice_clk[n]`.
- R7: The enable field is `cfg_wdata[5:3]`. Enable code 0 takes the enable of pin n from `gpio_oe[n]`.
- R8: Enable code 1 takes the enable of pin n from bit 0 of the tap of slice (n + 4) mod 16.
- R9: Enable codes 2, 3 and 4 select group widths 2, 4 and 8. The enable slice is (base + 4) mod 16, where base = n − n mod W. Its tap bit 0 gates the base pin, and its tap bit 1 gates every other pin of the group.
- R10: Reserved data codes 6 and 7 drive the pin to 0. Reserved enable codes 5, 6 and 7 drive the enable to 0.
- R11: Pin data and enables follow changes on `slice_tap`, `slice_clk`, `gpio_out` and `gpio_oe` within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Pin index of the word written |
| cfg_wdata | input | 6 | Word written: [2:0] data source, [5:3] enable source |
| slice_tap | input | 128 | Parallel taps, 8 bits per slice, slice s at [s*8 +: 8] |
| slice_clk | input | 16 | Slice clocks, one per slice |
| gpio_out | input | 16 | Static GPIO output bits |
| gpio_oe | input | 16 | Static output-enable bits |
| pin_out | output | 16 | Pin data |
| pin_oe | output | 16 | Pin output enables |

## Verification
The bench aims first at the group arithmetic. Wrong base rounding or a wrong bit offset makes upper pins of a 2-, 4- or 8-bit group copy the base pin or read a neighbouring slice. It also aims at the 8-bit legality rule on pins 8–15: a design that ignores the rule leaks slice 8's tap onto those pins instead of holding them low. Wide enable modes are driven with enable taps whose bit 0 and bit 1 differ, so a design that swaps the LSB and MSB roles, or feeds every pin of the group from one bit, shows wrong enables. Reserved codes and single-address writes are exercised by random configuration traffic. A decoder that aliases addresses or lets a reserved code fall through to a live source is then visible on some other pin.

// File: rtl/sgp_mux_pkg.sv
// Package: shared configuration word layout and code values for the
// serial slice output pin multiplexer.
// Assumes: data field in the low three bits, enable field above it.
package sgp_mux_pkg;

    // Per-pin configuration word; field order is software visible.
    typedef struct packed {
        logic [2:0] oe_sel;
        logic [2:0] data_sel;
    } pin_cfg_t;

    localparam int CFG_W = $bits(pin_cfg_t);

    // Data source codes
    localparam logic [2:0] DSRC_W1   = 3'd0;
    localparam logic [2:0] DSRC_W2   = 3'd1;
    localparam logic [2:0] DSRC_W4   = 3'd2;
    localparam logic [2:0] DSRC_W8   = 3'd3;
    localparam logic [2:0] DSRC_GPIO = 3'd4;
    localparam logic [2:0] DSRC_CLK  = 3'd5;

    // Output-enable source codes
    localparam logic [2:0] ESRC_STATIC = 3'd0;
    localparam logic [2:0] ESRC_E1     = 3'd1;
    localparam logic [2:0] ESRC_E2     = 3'd2;
    localparam logic [2:0] ESRC_E4     = 3'd3;
    localparam logic [2:0] ESRC_E8     = 3'd4;

    // Group base index of a pin for a group width (power of two).
    function automatic int group_base(input int pin, input int width);
        return pin - (pin % width);
    endfunction

endpackage

// File: rtl/sgp_cfg_bank.sv
// Module: per-pin configuration register bank.
// Holds one word per pin, written through a synchronous single-word
// port. Addresses at or above NUM_PINS are dropped.
// Assumes: synchronous active-low reset clears every word to zero.
module sgp_cfg_bank
    import sgp_mux_pkg::*;
#(
    parameter int NUM_PINS = 16,
    localparam int ADDR_W  = $clog2(NUM_PINS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [ADDR_W-1:0]         cfg_addr,
    input  logic [CFG_W-1:0]          cfg_wdata,
    output logic [NUM_PINS*CFG_W-1:0] cfg_flat
);

    generate
        for (genvar i = 0; i < NUM_PINS; i++) begin : g_word
            logic [CFG_W-1:0] word_q;
            logic             hit;

            // Address decode for this word
            always_comb hit = cfg_we && (cfg_addr == ADDR_W'(i));

            // Word register: clear on reset, load on a decoded write
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    word_q <= '0;
                end else if (hit) begin
                    word_q <= cfg_wdata;
                end
            end

            assign cfg_flat[i*CFG_W +: CFG_W] = word_q;
        end
    endgenerate

endmodule

// File: rtl/sgp_pin_data_sel.sv
// Module: data multiplexer for one pin.
// Picks slice data of width 1/2/4/8, a GPIO bit or a slice clock.
// Group geometry is fixed at elaboration from PIN_IDX.
// Assumes: one slice per pin, TAP_W >= 8, 8-bit legality given per
// group base slice in WIDE8_MASK. Reserved codes drive 0.
module sgp_pin_data_sel
    import sgp_mux_pkg::*;
#(
    parameter int                  NUM_PINS   = 16,
    parameter int                  TAP_W      = 8,
    parameter int                  PIN_IDX    = 0,
    parameter logic [NUM_PINS-1:0] WIDE8_MASK = NUM_PINS'(1)
) (
    input  logic [2:0]              data_sel,
    input  logic [NUM_PINS*TAP_W-1:0] slice_tap,
    input  logic [NUM_PINS-1:0]     slice_clk,
    input  logic                    gpio_bit,
    output logic                    pin_d
);

    localparam int B2 = group_base(PIN_IDX, 2);
    localparam int B4 = group_base(PIN_IDX, 4);
    localparam int B8 = group_base(PIN_IDX, 8);

    localparam int IDX1 = PIN_IDX * TAP_W;
    localparam int IDX2 = B2 * TAP_W + (PIN_IDX % 2);
    localparam int IDX4 = B4 * TAP_W + (PIN_IDX % 4);
    localparam int IDX8 = B8 * TAP_W + (PIN_IDX % 8);

    localparam logic LEGAL8 = WIDE8_MASK[B8];

    logic w8_bit;

    // 8-bit stream bit, forced low when the group base is not allowed
    always_comb w8_bit = LEGAL8 ? slice_tap[IDX8] : 1'b0;

    // Source selection by data code
    always_comb begin
        case (data_sel)
            DSRC_W1:   pin_d = slice_tap[IDX1];
            DSRC_W2:   pin_d = slice_tap[IDX2];
            DSRC_W4:   pin_d = slice_tap[IDX4];
            DSRC_W8:   pin_d = w8_bit;
            DSRC_GPIO: pin_d = gpio_bit;
            DSRC_CLK:  pin_d = slice_clk[PIN_IDX];
            default:   pin_d = 1'b0;
        endcase
    end

endmodule

// File: rtl/sgp_pin_oe_sel.sv
// Module: output-enable multiplexer for one pin.
// Takes the enable from a static bit or from a slice at a fixed offset.
// In group modes the base pin uses tap bit 0 of the enable slice and
// the other pins of the group use tap bit 1.
// Assumes: enable slice = (group base + OE_OFFSET) mod NUM_PINS.
module sgp_pin_oe_sel
    import sgp_mux_pkg::*;
#(
    parameter int NUM_PINS  = 16,
    parameter int TAP_W     = 8,
    parameter int PIN_IDX   = 0,
    parameter int OE_OFFSET = 4
) (
    input  logic [2:0]                oe_sel,
    input  logic [NUM_PINS*TAP_W-1:0] slice_tap,
    input  logic                      gpio_oe_bit,
    output logic                      pin_e
);

    localparam int B2 = group_base(PIN_IDX, 2);
    localparam int B4 = group_base(PIN_IDX, 4);
    localparam int B8 = group_base(PIN_IDX, 8);

    localparam int S1 = (PIN_IDX + OE_OFFSET) % NUM_PINS;
    localparam int S2 = (B2 + OE_OFFSET) % NUM_PINS;
    localparam int S4 = (B4 + OE_OFFSET) % NUM_PINS;
    localparam int S8 = (B8 + OE_OFFSET) % NUM_PINS;

    // Bit 0 for the group base pin, bit 1 for the higher pins
    localparam int K2 = (PIN_IDX == B2) ? 0 : 1;
    localparam int K4 = (PIN_IDX == B4) ? 0 : 1;
    localparam int K8 = (PIN_IDX == B8) ? 0 : 1;

    // Enable source selection by enable code
    always_comb begin
        case (oe_sel)
            ESRC_STATIC: pin_e = gpio_oe_bit;
            ESRC_E1:     pin_e = slice_tap[S1 * TAP_W];
            ESRC_E2:     pin_e = slice_tap[S2 * TAP_W + K2];
            ESRC_E4:     pin_e = slice_tap[S4 * TAP_W + K4];
            ESRC_E8:     pin_e = slice_tap[S8 * TAP_W + K8];
            default:     pin_e = 1'b0;
        endcase
    end

endmodule

// File: rtl/sgp_pin_mux.sv
// Module: serial slice output pin multiplexer, top level.
// Registers one configuration word per pin and builds, per pin, a data
// multiplexer and an enable multiplexer. Pin outputs are combinational
// from the registered words and the live inputs.
// Assumes: NUM_PINS slices, one per pin; TAP_W >= 8.
module sgp_pin_mux
    import sgp_mux_pkg::*;
#(
    parameter int                  NUM_PINS   = 16,
    parameter int                  TAP_W      = 8,
    parameter int                  OE_OFFSET  = 4,
    parameter logic [NUM_PINS-1:0] WIDE8_MASK = NUM_PINS'(1),
    localparam int                 ADDR_W     = $clog2(NUM_PINS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [ADDR_W-1:0]         cfg_addr,
    input  logic [CFG_W-1:0]          cfg_wdata,
    input  logic [NUM_PINS*TAP_W-1:0] slice_tap,
    input  logic [NUM_PINS-1:0]       slice_clk,
    input  logic [NUM_PINS-1:0]       gpio_out,
    input  logic [NUM_PINS-1:0]       gpio_oe,
    output logic [NUM_PINS-1:0]       pin_out,
    output logic [NUM_PINS-1:0]       pin_oe
);

    logic [NUM_PINS*CFG_W-1:0] cfg_flat;

    sgp_cfg_bank #(
        .NUM_PINS (NUM_PINS)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_flat  (cfg_flat)
    );

    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
            pin_cfg_t cfg;

            // Unpack this pin's word
            always_comb cfg = pin_cfg_t'(cfg_flat[p*CFG_W +: CFG_W]);

            sgp_pin_data_sel #(
                .NUM_PINS   (NUM_PINS),
                .TAP_W      (TAP_W),
                .PIN_IDX    (p),
                .WIDE8_MASK (WIDE8_MASK)
            ) u_dsel (
                .data_sel  (cfg.data_sel),
                .slice_tap (slice_tap),
                .slice_clk (slice_clk),
                .gpio_bit  (gpio_out[p]),
                .pin_d     (pin_out[p])
            );

            sgp_pin_oe_sel #(
                .NUM_PINS  (NUM_PINS),
                .TAP_W     (TAP_W),
                .PIN_IDX   (p),
                .OE_OFFSET (OE_OFFSET)
            ) u_esel (
                .oe_sel      (cfg.oe_sel),
                .slice_tap   (slice_tap),
                .gpio_oe_bit (gpio_oe[p]),
                .pin_e       (pin_oe[p])
            );
        end
    endgenerate

endmodule

// File: rtl/sgp_mux_checker.sv
// Module: assertion checker for the pin multiplexer, bound to the top.
// Relates the register write port, the stored words and the pins.
module sgp_mux_checker
    import sgp_mux_pkg::*;
#(
    parameter int NUM_PINS = 16,
    localparam int ADDR_W  = $clog2(NUM_PINS)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cfg_we,
    input logic [ADDR_W-1:0]         cfg_addr,
    input logic [CFG_W-1:0]          cfg_wdata,
    input logic [NUM_PINS*CFG_W-1:0] cfg_flat,
    input logic [NUM_PINS-1:0]       slice_clk,
    input logic [NUM_PINS-1:0]       gpio_out,
    input logic [NUM_PINS-1:0]       gpio_oe,
    input logic [NUM_PINS-1:0]       pin_out,
    input logic [NUM_PINS-1:0]       pin_oe
);

    generate
        for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
            // R1: a write to this address lands in this word
            a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_we && cfg_addr == ADDR_W'(i))
                |=> cfg_flat[i*CFG_W +: CFG_W] == $past(cfg_wdata));

            // R1: without a write to this address the word holds
            a_r1_word_holds: assert property (@(posedge clk) disable iff (!rst_n)
                !(cfg_we && cfg_addr == ADDR_W'(i))
                |=> $stable(cfg_flat[i*CFG_W +: CFG_W]));

            // R5: GPIO data code passes the GPIO bit
            a_r5_gpio_path: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_flat[i*CFG_W +: 3] == DSRC_GPIO) |-> pin_out[i] == gpio_out[i]);

            // R6: clock data code passes the slice clock
            a_r6_clock_path: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_flat[i*CFG_W +: 3] == DSRC_CLK) |-> pin_out[i] == slice_clk[i]);

            // R7: static enable code passes the enable register bit
            a_r7_static_oe: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_flat[i*CFG_W + 3 +: 3] == ESRC_STATIC) |-> pin_oe[i] == gpio_oe[i]);

            // R10: reserved data codes hold the pin low
            a_r10_rsv_data_low: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_flat[i*CFG_W +: 3] > DSRC_CLK) |-> !pin_out[i]);

            // R10: reserved enable codes hold the enable low
            a_r10_rsv_oe_low: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_flat[i*CFG_W + 3 +: 3] > ESRC_E8) |-> !pin_oe[i]);

            // R4: 8-bit code on pins of a disallowed group drives low
            if (i >= 8) begin : g_w8
                a_r4_w8_illegal_low: assert property (@(posedge clk) disable iff (!rst_n)
                    (cfg_flat[i*CFG_W +: 3] == DSRC_W8) |-> !pin_out[i]);
            end
        end
    endgenerate

endmodule

bind sgp_pin_mux sgp_mux_checker #(
    .NUM_PINS (NUM_PINS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_flat  (cfg_flat),
    .slice_clk (slice_clk),
    .gpio_out  (gpio_out),
    .gpio_oe   (gpio_oe),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/sgp_pin_mux_test.sv
// Bench: behavioural per-cycle reference model of the pin multiplexer,
// compared with the design on every falling edge.
module sgp_pin_mux_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic [3:0]   cfg_addr = '0;
    logic [5:0]   cfg_wdata = '0;
    logic [127:0] slice_tap = '0;
    logic [15:0]  slice_clk = '0;
    logic [15:0]  gpio_out = '0;
    logic [15:0]  gpio_oe = '0;
    logic [15:0]  pin_out;
    logic [15:0]  pin_oe;

    int checks = 0;
    int fails = 0;
    int mcfg [16];
    bit compare_on = 0;
    bit in_reset = 1;

    always #2 clk = ~clk;

    sgp_pin_mux uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .slice_tap (slice_tap),
        .slice_clk (slice_clk),
        .gpio_out  (gpio_out),
        .gpio_oe   (gpio_oe),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    // Model of the word registers (R1, R2)
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mcfg[i] = 0;
        end else if (cfg_we) begin
            mcfg[cfg_addr] = int'(cfg_wdata);
        end
    end

    // Expected pin data (R3 R4 R5 R6 R10)
    function automatic bit exp_d(input int n);
        int sel = mcfg[n] & 7;
        int w;
        int base;
        if (sel <= 3) begin
            w = 1 << sel;
            base = n - (n % w);
            if (sel == 3 && base != 0) return 1'b0;
            return slice_tap[base*8 + (n % w)];
        end
        if (sel == 4) return gpio_out[n];
        if (sel == 5) return slice_clk[n];
        return 1'b0;
    endfunction

    // Expected pin enable (R7 R8 R9 R10)
    function automatic bit exp_e(input int n);
        int sel = (mcfg[n] >> 3) & 7;
        int w;
        int base;
        if (sel == 0) return gpio_oe[n];
        if (sel == 1) return slice_tap[((n + 4) % 16) * 8];
        if (sel <= 4) begin
            w = 1 << (sel - 1);
            base = n - (n % w);
            return slice_tap[((base + 4) % 16) * 8 + ((n == base) ? 0 : 1)];
        end
        return 1'b0;
    endfunction

    function automatic string tag_d(input int n);
        int sel = mcfg[n] & 7;
        if (in_reset) return "R2";
        if (sel == 3 && n >= 8) return "R4";
        if (sel <= 3) return "R3";
        if (sel == 4) return "R5";
        if (sel == 5) return "R6";
        return "R10";
    endfunction

    function automatic string tag_e(input int n);
        int sel = (mcfg[n] >> 3) & 7;
        if (in_reset) return "R2";
        if (sel == 0) return "R7";
        if (sel == 1) return "R8";
        if (sel <= 4) return "R9";
        return "R10";
    endfunction

    // Per-cycle comparison; inputs changed after the rising edge, so
    // a match also shows the same-cycle path (R11, R1 via model words)
    always @(negedge clk) begin
        if (compare_on) begin
            for (int n = 0; n < 16; n++) begin
                checks++;
                if (pin_out[n] !== exp_d(n)) begin
                    fails++;
                    $display("FAIL %s (R1 R11) pin %0d data actual %0b expected %0b",
                             tag_d(n), n, pin_out[n], exp_d(n));
                end
                checks++;
                if (pin_oe[n] !== exp_e(n)) begin
                    fails++;
                    $display("FAIL %s (R1 R11) pin %0d enable actual %0b expected %0b",
                             tag_e(n), n, pin_oe[n], exp_e(n));
                end
            end
        end
    end

    task automatic shake_inputs();
        slice_tap = {$urandom, $urandom, $urandom, $urandom};
        slice_clk = 16'($urandom);
        gpio_out  = 16'($urandom);
        gpio_oe   = 16'($urandom);
    endtask

    // One cycle: new inputs after the edge, optional write
    task automatic step(input bit we, input int a, input int d);
        @(posedge clk);
        #1;
        shake_inputs();
        cfg_we    = we;
        cfg_addr  = 4'(a);
        cfg_wdata = 6'(d);
    endtask

    // Set every pin to one word, then hold for a few cycles
    task automatic all_pins(input int d, input int hold);
        for (int p = 0; p < 16; p++) step(1'b1, p, d);
        for (int h = 0; h < hold; h++) step(1'b0, 0, 0);
    endtask

    initial begin
        // R2: reset state, compared while reset is held
        step(1'b0, 0, 0);
        compare_on = 1;
        for (int c = 0; c < 4; c++) step(1'b1, c, 6'h3f);
        step(1'b0, 0, 0);
        rst_n = 1'b1;
        in_reset = 0;
        for (int c = 0; c < 4; c++) step(1'b0, 0, 0);

        // Directed sweep: every data code with every enable code
        for (int e = 0; e < 8; e++) begin
            for (int d = 0; d < 8; d++) all_pins((e << 3) | d, 6);
        end

        // R1: a single write amid others left at defaults
        all_pins(0, 2);
        step(1'b1, 9, 6'h04);
        for (int h = 0; h < 8; h++) step(1'b0, 0, 0);

        // Random configuration traffic with reserved codes
        for (int c = 0; c < 3000; c++) begin
            step(($urandom % 3) == 0, int'($urandom % 16), int'($urandom % 64));
        end

        step(1'b0, 0, 0);
        @(negedge clk);
        #1;
        compare_on = 0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog R1 actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule